// File: doc/BRIEF.md
# Chip-Select Wait-State and Bus-Drive Controller

This block controls one memory region on a shared, multiplexed address/data bus. A 16-bit control word sets the region's timing. It holds a two-bit count of added wait states, a bit that says whether an external ready input is honoured, a bit that can silence the bus during the address phase, and an enable for pseudo-static RAM support.

Address decoding happens outside the block. When a bus cycle hits the region, a one-clock start pulse launches the sequence. The sequence runs an address phase, then a data phase, then the programmed wait states, then any wait states added by the ready input, and last an end phase. Chip select stays high from the address phase through the end phase. A registered output-enable tells the bus driver whether to put the address on the shared lines.

A strap input is latched while reset is held. The value present at the last clock before reset is released stays in force. When the strap is low, the address is always driven, whatever the control word says.

Top module: `csw_region_ctrl`

## Requirements
- R1: After reset the control word reads 16'h0F3B (no address suppression, pseudo-static RAM off, ready required, three wait states), and chip select, output-enable and done are low.
- R2: Bits 11:8 and 5:3 of the control word always read as 1 and bits 15:12 always read as 0, whatever value is written. Writable fields are: bit 7 address-suppress, bit 6 pseudo-static RAM enable, bit 2 ready-ignore, bits 1:0 wait count.
- R3: With ready-ignore set, a cycle holds chip select for exactly 3 + N clocks, where N is the wait count (0 to 3). Done is high only in the last of those clocks.
- R4: With ready-ignore clear, the ready input is sampled only once the N wait states have elapsed. Each sampled low adds one clock before the end phase.
- R5: With ready-ignore set, a low ready input has no effect on cycle length.
- R6: The output-enable is high only in the first chip-select clock (the address phase). It stays low for the whole cycle when address-suppress is 1 and the latched strap is high.
- R7: If the strap was low when reset was released, the output-enable is high in every address phase, even with address-suppress set. Later strap changes have no effect until the next reset.
- R8: A control-word write made while a cycle is running does not change that cycle. The write applies from the next cycle on.
- R9: The pseudo-static RAM enable output follows bit 6 of the control word.
- R10: A start pulse that arrives while a cycle is in progress is ignored, and no extra cycle follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_i | input | 1 | Address-drive strap, latched while reset is high |
| cfg_we_i | input | 1 | Control-word write enable |
| cfg_wdata_i | input | 16 | Control-word write data |
| cfg_rdata_o | output | 16 | Control-word read value |
| start_i | input | 1 | Pulse: a bus cycle hits this region |
| ready_i | input | 1 | External ready |
| cs_o | output | 1 | Region chip select, active high |
| ad_oe_o | output | 1 | Address-phase drive enable for the shared lines |
| done_o | output | 1 | High in the end phase of a cycle |
| psram_en_o | output | 1 | Pseudo-static RAM support enable |

## Verification
A control-word write shows on the read port right after the clock edge that takes it. Chip select and the output-enable rise one edge after start is sampled. Done arrives 3 + N + X clocks into the cycle, where X is the number of ready-low samples after the wait count runs out. The bench drives inputs on falling edges, holds ready low for exactly the edges that must see it low, and queues the expected length and drive decision for each cycle. A falling-edge monitor counts chip-select clocks, records the output-enable in the first of them, and compares against the queue when done appears.

// File: rtl/csw_pkg.sv
package csw_pkg;

    localparam int CFG_W = 16;
    localparam int WS_W  = 2;

    localparam int B_ADIS  = 7;
    localparam int B_PSRAM = 6;
    localparam int B_RIGN  = 2;

    localparam logic [CFG_W-1:0] RSVD_ONES = 16'h0F38;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_DATA,
        PH_WAIT,
        PH_END
    } phase_e;

    typedef struct packed {
        logic            adis;
        logic            psram;
        logic            rdy_ign;
        logic [WS_W-1:0] ws;
    } cfg_t;

    localparam cfg_t CFG_RST = '{adis: 1'b0, psram: 1'b0, rdy_ign: 1'b0, ws: '1};

    function automatic logic [CFG_W-1:0] pack_cfg(input cfg_t c);
        logic [CFG_W-1:0] r;
        r             = RSVD_ONES;
        r[B_ADIS]     = c.adis;
        r[B_PSRAM]    = c.psram;
        r[B_RIGN]     = c.rdy_ign;
        r[WS_W-1:0]   = c.ws;
        return r;
    endfunction

    function automatic cfg_t unpack_cfg(input logic [CFG_W-1:0] w);
        cfg_t c;
        c.adis    = w[B_ADIS];
        c.psram   = w[B_PSRAM];
        c.rdy_ign = w[B_RIGN];
        c.ws      = w[WS_W-1:0];
        return c;
    endfunction

    function automatic logic drive_addr(input cfg_t c, input logic strap);
        return !(c.adis && strap);
    endfunction

endpackage

// File: rtl/csw_cfg.sv
module csw_cfg
    import csw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             strap_i,
    input  logic             we_i,
    input  logic [CFG_W-1:0] wdata_i,
    output logic [CFG_W-1:0] rdata_o,
    output cfg_t             cfg_o,
    output logic             strap_o
);

    cfg_t cfg_q;
    logic strap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= CFG_RST;
            strap_q <= strap_i;
        end else if (we_i) begin
            cfg_q   <= unpack_cfg(wdata_i);
        end
    end

    assign cfg_o   = cfg_q;
    assign strap_o = strap_q;
    assign rdata_o = pack_cfg(cfg_q);

    // R7: latched strap holds after reset release
    p_strap_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(strap_q));

endmodule

// File: rtl/csw_seq.sv
module csw_seq
    import csw_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic ready_i,
    input  cfg_t cfg_i,
    input  logic strap_i,
    output logic cs_o,
    output logic ad_oe_o,
    output logic done_o
);

    phase_e          st, nxt;
    cfg_t            snap;
    logic [WS_W-1:0] cnt;
    logic            oe_q;
    logic            in_wait;
    logic            launch;

    assign in_wait = (st == PH_DATA) || (st == PH_WAIT);
    assign launch  = (st == PH_IDLE) && start_i;

    always_comb begin
        nxt = st;
        case (st)
            PH_IDLE: if (start_i) nxt = PH_ADDR;
            PH_ADDR: nxt = PH_DATA;
            PH_DATA,
            PH_WAIT: begin
                if (cnt == '0 && (snap.rdy_ign || ready_i)) nxt = PH_END;
                else                                       nxt = PH_WAIT;
            end
            PH_END:  nxt = PH_IDLE;
            default: nxt = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= PH_IDLE;
            snap <= CFG_RST;
            cnt  <= '0;
            oe_q <= 1'b0;
        end else begin
            st   <= nxt;
            oe_q <= launch && drive_addr(cfg_i, strap_i);
            if (launch) begin
                snap <= cfg_i;
                cnt  <= cfg_i.ws;
            end else if (in_wait && cnt != '0) begin
                cnt  <= cnt - 1'b1;
            end
        end
    end

    assign cs_o    = (st != PH_IDLE);
    assign done_o  = (st == PH_END);
    assign ad_oe_o = oe_q;

    p_oe_addr_only_r6: assert property (@(posedge clk) disable iff (rst)
        ad_oe_o |-> (st == PH_ADDR));
    p_addr_then_data_r3: assert property (@(posedge clk) disable iff (rst)
        (st == PH_ADDR) |=> (st == PH_DATA));
    p_waits_first_r3: assert property (@(posedge clk) disable iff (rst)
        (in_wait && cnt != '0) |=> (st == PH_WAIT));
    p_end_to_idle_r3: assert property (@(posedge clk) disable iff (rst)
        (st == PH_END) |=> (st == PH_IDLE));
    p_ready_stall_r4: assert property (@(posedge clk) disable iff (rst)
        (in_wait && cnt == '0 && !snap.rdy_ign && !ready_i) |=> (st == PH_WAIT));
    p_ready_ignored_r5: assert property (@(posedge clk) disable iff (rst)
        (in_wait && cnt == '0 && snap.rdy_ign) |=> (st == PH_END));
    p_snap_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (cs_o && $past(cs_o)) |-> $stable(snap));
    p_no_restart_r10: assert property (@(posedge clk) disable iff (rst)
        (cs_o && st != PH_END) |=> (st != PH_ADDR));

endmodule

// File: rtl/csw_region_ctrl.sv
module csw_region_ctrl
    import csw_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        strap_i,
    input  logic        cfg_we_i,
    input  logic [15:0] cfg_wdata_i,
    output logic [15:0] cfg_rdata_o,
    input  logic        start_i,
    input  logic        ready_i,
    output logic        cs_o,
    output logic        ad_oe_o,
    output logic        done_o,
    output logic        psram_en_o
);

    cfg_t cfg;
    logic strap_q;

    csw_cfg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .strap_i (strap_i),
        .we_i    (cfg_we_i),
        .wdata_i (cfg_wdata_i),
        .rdata_o (cfg_rdata_o),
        .cfg_o   (cfg),
        .strap_o (strap_q)
    );

    csw_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .ready_i (ready_i),
        .cfg_i   (cfg),
        .strap_i (strap_q),
        .cs_o    (cs_o),
        .ad_oe_o (ad_oe_o),
        .done_o  (done_o)
    );

    assign psram_en_o = cfg.psram;

    // R3: done only inside an active chip select
    p_done_in_cs_r3: assert property (@(posedge clk) disable iff (rst)
        done_o |-> cs_o);

endmodule

// File: tb/test_csw_region_ctrl.sv
module test_csw_region_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        strap_i = 1'b1;
    logic        cfg_we_i = 1'b0;
    logic [15:0] cfg_wdata_i = '0;
    logic [15:0] cfg_rdata_o;
    logic        start_i = 1'b0;
    logic        ready_i = 1'b1;
    logic        cs_o, ad_oe_o, done_o, psram_en_o;

    always #4 clk = ~clk;

    csw_region_ctrl i_csw_region_ctrl (
        .clk(clk), .rst(rst), .strap_i(strap_i),
        .cfg_we_i(cfg_we_i), .cfg_wdata_i(cfg_wdata_i), .cfg_rdata_o(cfg_rdata_o),
        .start_i(start_i), .ready_i(ready_i),
        .cs_o(cs_o), .ad_oe_o(ad_oe_o), .done_o(done_o), .psram_en_o(psram_en_o)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    finished = 0;
    int    q_len[$];
    bit    q_oe[$];
    string q_req[$];

    task automatic check(input string req, input int got, input int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    function automatic logic [15:0] cval(input bit adis, input bit ps, input bit ign, input int w);
        return 16'h0F38 | (16'(adis) << 7) | (16'(ps) << 6) | (16'(ign) << 2) | 16'(w & 3);
    endfunction

    // monitor / scoreboard
    int run_len = 0;
    bit seen_oe = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (cs_o) begin
                run_len++;
                if (run_len == 1) seen_oe = ad_oe_o;
                else if (ad_oe_o) check("R6 oe outside address phase", 1, 0);
            end
            if (done_o) begin
                if (q_len.size() == 0) begin
                    check("R10 unexpected cycle", 1, 0);
                end else begin
                    string r;
                    int    l;
                    bit    o;
                    r = q_req.pop_front();
                    l = q_len.pop_front();
                    o = q_oe.pop_front();
                    check({r, " length"}, run_len, l);
                    check({r, " address drive"}, int'(seen_oe), int'(o));
                end
                run_len = 0;
            end
        end
    end

    task automatic do_reset(input bit strap);
        rst = 1'b1;
        strap_i = strap;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        strap_i = ~strap;
        run_len = 0;
    endtask

    task automatic wr_cfg(input logic [15:0] v);
        @(negedge clk);
        cfg_we_i = 1'b1;
        cfg_wdata_i = v;
        @(posedge clk);
        @(negedge clk);
        cfg_we_i = 1'b0;
    endtask

    task automatic run_cyc(input string req, input int w, input bit ign, input int x,
                           input bit exp_oe, input bit mid_wr, input logic [15:0] mid_val,
                           input bit poke);
        q_req.push_back(req);
        q_len.push_back(ign ? 3 + w : 3 + w + x);
        q_oe.push_back(exp_oe);
        @(negedge clk);
        start_i = 1'b1;
        ready_i = (ign || x > 0) ? 1'b0 : 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = poke;
        cfg_we_i = mid_wr;
        cfg_wdata_i = mid_val;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        cfg_we_i = 1'b0;
        if (!ign) begin
            repeat (w + x) @(posedge clk);
            @(negedge clk);
            ready_i = 1'b1;
        end
        while (cs_o) @(negedge clk);
        ready_i = 1'b1;
        if (poke) begin
            for (int k = 0; k < 3; k++) begin
                check("R10 no extra cycle", int'(cs_o), 0);
                @(negedge clk);
            end
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset(1'b1);
        @(negedge clk);
        check("R1 reset word", int'(cfg_rdata_o), 16'h0F3B);
        check("R1 cs", int'(cs_o), 0);
        check("R1 oe", int'(ad_oe_o), 0);
        check("R1 done", int'(done_o), 0);

        wr_cfg(16'h0000);
        check("R2 reserved after zero write", int'(cfg_rdata_o), 16'h0F38);
        check("R9 psram off", int'(psram_en_o), 0);
        wr_cfg(16'hFFFF);
        check("R2 reserved after ones write", int'(cfg_rdata_o), 16'h0FFF);
        check("R9 psram on", int'(psram_en_o), 1);

        // R3 / R5: ready ignored, held low throughout
        for (int w = 0; w < 4; w++) begin
            wr_cfg(cval(0, 0, 1, w));
            run_cyc("R3 R5 ignored ready", w, 1, 0, 1'b1, 1'b0, 16'h0, 1'b0);
        end

        // R4: ready required
        wr_cfg(cval(0, 0, 0, 1));
        run_cyc("R4 w1 x2", 1, 0, 2, 1'b1, 1'b0, 16'h0, 1'b0);
        wr_cfg(cval(0, 0, 0, 0));
        run_cyc("R4 w0 x3", 0, 0, 3, 1'b1, 1'b0, 16'h0, 1'b0);
        wr_cfg(cval(0, 0, 0, 3));
        run_cyc("R4 w3 x1", 3, 0, 1, 1'b1, 1'b0, 16'h0, 1'b0);
        run_cyc("R4 w3 x0", 3, 0, 0, 1'b1, 1'b0, 16'h0, 1'b0);

        // R6: suppression with strap high
        wr_cfg(cval(1, 0, 1, 2));
        run_cyc("R6 suppressed", 2, 1, 0, 1'b0, 1'b0, 16'h0, 1'b0);

        // R8: mid-cycle write
        wr_cfg(cval(0, 0, 1, 0));
        run_cyc("R8 old config", 0, 1, 0, 1'b1, 1'b1, cval(1, 0, 1, 3), 1'b0);
        run_cyc("R8 new config", 3, 1, 0, 1'b0, 1'b0, 16'h0, 1'b0);

        // R10: start while busy
        wr_cfg(cval(0, 0, 1, 2));
        run_cyc("R10 poke", 2, 1, 0, 1'b1, 1'b0, 16'h0, 1'b1);

        // R7: strap low at release
        do_reset(1'b0);
        wr_cfg(cval(1, 0, 1, 1));
        run_cyc("R7 strap low forces drive", 1, 1, 0, 1'b1, 1'b0, 16'h0, 1'b0);

        repeat (3) @(negedge clk);
        check("queue drained", q_len.size(), 0);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule